// File: doc/BRIEF.md
# BFloat16 Vector Clamp Unit

This unit bounds every 16-bit BFloat16 lane of an accumulator vector between a per-lane floor and a per-lane ceiling. It takes three equal-width vectors: the accumulator, a lower-bound vector and an upper-bound vector. It returns one vector of the same width, which the surrounding datapath writes back over the accumulator.

Each lane first takes the number-preferring maximum of the floor and the accumulator. It then takes the number-preferring minimum of that value and the ceiling. The unit raises an invalid-operation flag when any lane or stage meets a signalling NaN or two NaN operands. All lanes are always written.

An optional decoder compares a 32-bit instruction word against the clamp encoding. It extracts the three register indices. It blocks the result, and reports an undefined instruction, when the BFloat16 arithmetic feature input is low.

Top module: `bfc_clamp_unit`

## Requirements
- R1: The vector width is the parameter VL (default 128). It holds VL/16 independent lanes, and lane e occupies bits [16e+15:16e]. Every lane of the output is written on each accepted operation, with no merge of old contents.
- R2: Per lane the result is min(max(lower, acc), upper). If the bounds cross (lower > upper), the result is the upper bound.
- R3: out_valid pulses high in the cycle after a clock edge that accepts in_valid. out_vec and out_invalid are registered with it. While out_valid is low, out_vec holds its last value.
- R4: A NaN is any pattern with exponent bits [14:7] all ones and a non-zero fraction [6:0]. It is quiet when bit 6 is set. If exactly one operand of a max or min step is a quiet NaN, that step returns the other operand unchanged.
- R5: If both operands of a step are NaN, or either is a signalling NaN, that step returns 16'h7FC0 and flags the lane invalid.
- R6: Negative zero (16'h8000) orders below positive zero (16'h0000). max gives +0 and min gives -0.
- R7: Ordering is sign-magnitude on the raw 16-bit patterns, including infinities. Subnormals are compared exactly, with no flush to zero.
- R8: out_invalid is the OR of the invalid conditions from both stages of all lanes of the accepted operation. It is low whenever out_valid is low.
- R9: insn_hit is high when insn_word[31:21] = 11'b01100100001 and insn_word[15:10] = 6'b001001. idx_hi = insn_word[20:16], idx_lo = insn_word[9:5] and idx_dst = insn_word[4:0].
- R10: With CHECK_DECODE = 1, a matching word presented with in_valid while feat_en is low gives out_undef high for one cycle. It gives no out_valid, and out_vec is unchanged.
- R11: With CHECK_DECODE = 1, in_valid with a non-matching word is ignored. out_valid, out_undef and out_invalid stay low and out_vec is unchanged.
- R12: While rst_n is low, out_valid, out_invalid and out_undef are low and out_vec is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and word presented this cycle |
| feat_en | input | 1 | BFloat16 arithmetic feature available |
| insn_word | input | 32 | Instruction word for the decode check |
| acc_vec | input | VL | Accumulator (destination) vector |
| lo_vec | input | VL | Lower-bound vector |
| hi_vec | input | VL | Upper-bound vector |
| insn_hit | output | 1 | Word matches the clamp encoding (combinational) |
| idx_dst | output | 5 | Destination register index |
| idx_lo | output | 5 | Lower-bound register index |
| idx_hi | output | 5 | Upper-bound register index |
| out_valid | output | 1 | Clamped vector ready |
| out_vec | output | VL | Clamped vector |
| out_invalid | output | 1 | Invalid-operation flag for the result |
| out_undef | output | 1 | Undefined-instruction indication |

## Verification
The decode outputs are combinational, so the bench checks them in the same cycle it drives the word. The clamped vector, the invalid flag and the undefined indication come out of a single register stage and are due one edge after the accepting edge. The bench drives every input on the falling edge and lets one rising edge pass. It samples all registered outputs at the next falling edge, and it deasserts in_valid there, so each check sees exactly one accepted operation. For the hold and ignore cases, the bench compares out_vec against the value it recorded from the previous accepted result.

// File: rtl/bfc_pkg.sv
// Package: shared BFloat16 constants and lane helper functions.
// Assumes 16-bit lanes: sign [15], exponent [14:7], fraction [6:0].
package bfc_pkg;
    localparam int          LANE_W  = 16;
    localparam logic [15:0] BF_DNAN = 16'h7FC0;

    // True for any NaN pattern (all-ones exponent, non-zero fraction)
    function automatic logic bf_is_nan(input logic [15:0] v);
        return (v[14:7] == 8'hFF) && (v[6:0] != 7'd0);
    endfunction

    // True for a signalling NaN (quiet bit 6 clear)
    function automatic logic bf_is_snan(input logic [15:0] v);
        return bf_is_nan(v) && !v[6];
    endfunction

    // Strict sign-magnitude less-than; -0 orders below +0
    function automatic logic bf_less(input logic [15:0] a, input logic [15:0] b);
        logic lt;
        if (a[15] != b[15])
            lt = a[15];
        else if (!a[15])
            lt = a[14:0] < b[14:0];
        else
            lt = a[14:0] > b[14:0];
        return lt;
    endfunction
endpackage

// File: rtl/bfc_numsel.sv
// Module: one number-preferring max or min step on a single lane.
// PICK_MAX selects the variant. A lone quiet NaN yields the other operand;
// two NaNs or any signalling NaN yield the default NaN and raise inv.
module bfc_numsel
    import bfc_pkg::*;
#(
    parameter bit PICK_MAX = 1'b1
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] y,
    output logic              inv
);
    logic a_nan, b_nan, a_lt_b;
    logic [LANE_W-1:0] ordered;

    // classify operands and compare them
    always_comb begin
        a_nan  = bf_is_nan(a);
        b_nan  = bf_is_nan(b);
        a_lt_b = bf_less(a, b);
    end

    generate
        if (PICK_MAX) begin : g_max
            // larger of two numbers
            always_comb ordered = a_lt_b ? b : a;
        end else begin : g_min
            // smaller of two numbers
            always_comb ordered = a_lt_b ? a : b;
        end
    endgenerate

    // apply NaN rules on top of the ordered pick
    always_comb begin
        inv = (a_nan && b_nan) || bf_is_snan(a) || bf_is_snan(b);
        if (inv)        y = BF_DNAN;
        else if (a_nan) y = b;
        else if (b_nan) y = a;
        else            y = ordered;
    end
endmodule

// File: rtl/bfc_lane.sv
// Module: clamps one lane as min(max(lo, acc), hi).
// Assumes operands are raw BFloat16 patterns; purely combinational.
module bfc_lane
    import bfc_pkg::*;
(
    input  logic [LANE_W-1:0] acc,
    input  logic [LANE_W-1:0] lo,
    input  logic [LANE_W-1:0] hi,
    output logic [LANE_W-1:0] res,
    output logic              inv
);
    logic [LANE_W-1:0] floor_v;
    logic              inv_max, inv_min;

    bfc_numsel #(.PICK_MAX(1'b1)) u_max (
        .a(lo), .b(acc), .y(floor_v), .inv(inv_max)
    );

    bfc_numsel #(.PICK_MAX(1'b0)) u_min (
        .a(floor_v), .b(hi), .y(res), .inv(inv_min)
    );

    // either stage flags the lane invalid
    always_comb inv = inv_max || inv_min;
endmodule

// File: rtl/bfc_decode.sv
// Module: matches the 32-bit clamp encoding and extracts register indices.
// Assumes a fixed opcode split across [31:21] and [15:10].
module bfc_decode #(
    parameter logic [10:0] OPC_HI  = 11'b01100100001,
    parameter logic [5:0]  OPC_MID = 6'b001001
) (
    input  logic [31:0] word,
    output logic        hit,
    output logic [4:0]  r_dst,
    output logic [4:0]  r_lo,
    output logic [4:0]  r_hi
);
    // compare fixed fields and slice index fields
    always_comb begin
        hit   = (word[31:21] == OPC_HI) && (word[15:10] == OPC_MID);
        r_hi  = word[20:16];
        r_lo  = word[9:5];
        r_dst = word[4:0];
    end
endmodule

// File: rtl/bfc_clamp_unit.sv
// Module: top of the BFloat16 vector clamp. Instantiates VL/16 lanes and the
// decoder, and registers the result one cycle after an accepted in_valid.
// Assumes VL is a multiple of 16. With CHECK_DECODE=0 every in_valid is accepted.
module bfc_clamp_unit
    import bfc_pkg::*;
#(
    parameter int VL           = 128,
    parameter bit CHECK_DECODE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          feat_en,
    input  logic [31:0]   insn_word,
    input  logic [VL-1:0] acc_vec,
    input  logic [VL-1:0] lo_vec,
    input  logic [VL-1:0] hi_vec,
    output logic          insn_hit,
    output logic [4:0]    idx_dst,
    output logic [4:0]    idx_lo,
    output logic [4:0]    idx_hi,
    output logic          out_valid,
    output logic [VL-1:0] out_vec,
    output logic          out_invalid,
    output logic          out_undef
);
    localparam int LANES = VL / LANE_W;

    logic [VL-1:0]    lane_res;
    logic [LANES-1:0] lane_inv;
    logic             fire, undef_now;

    bfc_decode u_dec (
        .word(insn_word), .hit(insn_hit),
        .r_dst(idx_dst), .r_lo(idx_lo), .r_hi(idx_hi)
    );

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        bfc_lane u_lane (
            .acc(acc_vec[e*LANE_W +: LANE_W]),
            .lo (lo_vec [e*LANE_W +: LANE_W]),
            .hi (hi_vec [e*LANE_W +: LANE_W]),
            .res(lane_res[e*LANE_W +: LANE_W]),
            .inv(lane_inv[e])
        );
    end

    generate
        if (CHECK_DECODE) begin : g_chk
            // accept only a matching word with the feature present
            always_comb begin
                fire      = in_valid && insn_hit && feat_en;
                undef_now = in_valid && insn_hit && !feat_en;
            end
        end else begin : g_nochk
            // accept every presented operation
            always_comb begin
                fire      = in_valid;
                undef_now = 1'b0;
            end
        end
    endgenerate

    // result register: loads on fire, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_invalid <= 1'b0;
            out_undef   <= 1'b0;
            out_vec     <= '0;
        end else begin
            out_valid   <= fire;
            out_invalid <= fire && (|lane_inv);
            out_undef   <= undef_now;
            if (fire)
                out_vec <= lane_res;
        end
    end
endmodule

// File: rtl/bfc_clamp_chk.sv
// Module: assertion checker for bfc_clamp_unit, attached by bind.
// Assumes synchronous active-low reset on the same clock.
module bfc_clamp_chk #(
    parameter int VL = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          feat_en,
    input logic          out_valid,
    input logic [VL-1:0] out_vec,
    input logic          out_invalid,
    input logic          out_undef
);
    // R3
    valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_vec));
    // R8
    invalid_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_valid);
    // R10
    undef_blocks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> !out_valid);
    // R10
    undef_needs_nofeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> ($past(in_valid) && !$past(feat_en)));
endmodule

bind bfc_clamp_unit bfc_clamp_chk #(.VL(VL)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .feat_en(feat_en),
    .out_valid(out_valid), .out_vec(out_vec),
    .out_invalid(out_invalid), .out_undef(out_undef)
);

// File: tb/tb_bfc_clamp_unit.sv
module tb_bfc_clamp_unit;
    localparam int VL    = 128;
    localparam int LANES = VL / 16;
    localparam int NV    = 18;
    localparam logic [31:0] GOOD_WORD = 32'b01100100001_00011_001001_00010_00001;

    // entry: {acc, lo, hi, expected, invalid}
    localparam logic [64:0] TBL [NV] = '{
        {16'h3F80, 16'h3F00, 16'h4000, 16'h3F80, 1'b0},  // R2 inside
        {16'h4040, 16'h3F00, 16'h4000, 16'h4000, 1'b0},  // R2 above
        {16'hBF80, 16'h3F00, 16'h4000, 16'h3F00, 1'b0},  // R2 below
        {16'h3F80, 16'h4040, 16'h4000, 16'h4000, 1'b0},  // R2 crossed bounds
        {16'h7FC0, 16'h3F00, 16'h4000, 16'h3F00, 1'b0},  // R4 qNaN acc
        {16'h3F80, 16'hFFC1, 16'h4000, 16'h3F80, 1'b0},  // R4 qNaN lo
        {16'h3F80, 16'h3F00, 16'h7FC0, 16'h3F80, 1'b0},  // R4 qNaN hi
        {16'h7FC0, 16'hFFC1, 16'h4000, 16'h4000, 1'b1},  // R5 two NaNs
        {16'h7F81, 16'h3F00, 16'h4000, 16'h4000, 1'b1},  // R5 sNaN acc
        {16'h3F80, 16'h3F00, 16'h7F81, 16'h7FC0, 1'b1},  // R5 sNaN hi
        {16'h8000, 16'h0000, 16'h4000, 16'h0000, 1'b0},  // R6 max gives +0
        {16'h0000, 16'h8000, 16'h8000, 16'h8000, 1'b0},  // R6 min gives -0
        {16'h0002, 16'h0001, 16'h0003, 16'h0002, 1'b0},  // R7 subnormal inside
        {16'h0001, 16'h0002, 16'h0003, 16'h0002, 1'b0},  // R7 subnormal below
        {16'hBF80, 16'hC000, 16'hBF00, 16'hBF80, 1'b0},  // R7 negatives inside
        {16'hC040, 16'hC000, 16'hBF00, 16'hC000, 1'b0},  // R7 negatives below
        {16'h7F80, 16'hFF80, 16'h7F80, 16'h7F80, 1'b0},  // R7 infinities
        {16'h7FC0, 16'h7FC0, 16'h7FC0, 16'h7FC0, 1'b1}   // R5 all NaN
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          feat_en = 1'b1;
    logic [31:0]   insn_word = GOOD_WORD;
    logic [VL-1:0] acc_vec = '0, lo_vec = '0, hi_vec = '0;
    logic          insn_hit, out_valid, out_invalid, out_undef;
    logic [4:0]    idx_dst, idx_lo, idx_hi;
    logic [VL-1:0] out_vec;

    int checks = 0;
    int fails  = 0;
    logic [VL-1:0] exp_vec, last_vec;
    logic          exp_inv;

    always #2 clk = ~clk;

    bfc_clamp_unit #(.VL(VL), .CHECK_DECODE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .feat_en(feat_en),
        .insn_word(insn_word), .acc_vec(acc_vec), .lo_vec(lo_vec), .hi_vec(hi_vec),
        .insn_hit(insn_hit), .idx_dst(idx_dst), .idx_lo(idx_lo), .idx_hi(idx_hi),
        .out_valid(out_valid), .out_vec(out_vec),
        .out_invalid(out_invalid), .out_undef(out_undef)
    );

    task automatic check(input string req, input logic [VL-1:0] act,
                         input logic [VL-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // present one operation at a falling edge, sample at the next falling edge
    task automatic issue();
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R12 reset state, in_valid held high during reset
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 out_valid", VL'(out_valid), '0);
        check("R12 out_invalid", VL'(out_invalid), '0);
        check("R12 out_undef", VL'(out_undef), '0);
        check("R12 out_vec", out_vec, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R9 decode fields
        check("R9 hit", VL'(insn_hit), VL'(1));
        check("R9 idx", VL'({idx_hi, idx_lo, idx_dst}), VL'({5'd3, 5'd2, 5'd1}));

        // R1 R2 R4 R5 R6 R7 R8: table walk, lane L takes entry (i+L)%NV
        for (int i = 0; i < NV; i++) begin
            exp_inv = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                acc_vec[l*16 +: 16] = TBL[(i+l)%NV][64:49];
                lo_vec [l*16 +: 16] = TBL[(i+l)%NV][48:33];
                hi_vec [l*16 +: 16] = TBL[(i+l)%NV][32:17];
                exp_vec[l*16 +: 16] = TBL[(i+l)%NV][16:1];
                exp_inv = exp_inv | TBL[(i+l)%NV][0];
            end
            issue();
            check("R3 valid", VL'(out_valid), VL'(1));
            check("R1 R2 lanes", out_vec, exp_vec);
            check("R8 invalid", VL'(out_invalid), VL'(exp_inv));
        end
        last_vec = exp_vec;

        // R3 hold while idle
        @(negedge clk);
        check("R3 idle valid", VL'(out_valid), '0);
        check("R3 hold vec", out_vec, last_vec);
        check("R8 idle invalid", VL'(out_invalid), '0);

        // R11 non-matching word ignored
        acc_vec = '0; lo_vec = '0; hi_vec = '0;
        insn_word = GOOD_WORD ^ 32'h0000_0400;
        @(negedge clk);
        check("R9 miss", VL'(insn_hit), '0);
        issue();
        check("R11 no valid", VL'(out_valid), '0);
        check("R11 no undef", VL'(out_undef), '0);
        check("R11 vec kept", out_vec, last_vec);

        // R10 feature off
        insn_word = GOOD_WORD;
        feat_en = 1'b0;
        issue();
        check("R10 undef", VL'(out_undef), VL'(1));
        check("R10 no valid", VL'(out_valid), '0);
        check("R10 vec kept", out_vec, last_vec);
        feat_en = 1'b1;
        @(negedge clk);
        check("R10 undef one cycle", VL'(out_undef), '0);

        // R1 every lane overwritten with zeros
        issue();
        check("R1 full overwrite", out_vec, '0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule